// File: doc/BRIEF.md
# Debounced Key Matrix Scanner

This block reads a keypad built as a grid of drive lines and sense inputs (six by five by default, thirty keys). It does not scan on a fixed period. While it is idle it holds every drive line at a standby level, and it starts scanning only when some sense input goes high. One scan raises the drive lines one at a time, each for an equal slot, and samples the sense inputs near the end of each slot. Two scans in a row must agree before a key image is accepted. When they do, the image is latched and an active-low request flag is raised toward a host.

After the host has read the image, it pulses a read-done strobe. The request is then released and a fresh scan round begins. Once a round in which every key reads released has agreed, the block goes back to idle. The standby pattern on the drive lines follows the two sleep bits, so in sleep only a press on a line that is held high can wake the block. The block reports whether it was asleep when the press began, and it drives an oscillator enable that is high whenever work is pending. A chip-enable input from the serial side masks the request. The two lowest drive lines can be given over to other use; they are then never driven, and their keys read as zero.

Top module: `key_matrix_scanner`

## Requirements
- R1: While `rst_n` is low, `key_o` is all zero, `sleep_ack_o` is 0 and `req_n_o` is 1, and no press starts a scan.
- R2: In idle, a high sense input starts a scan on the next clock edge. When the first two scans agree on a non-empty image, `req_n_o` falls exactly ROUND_CYC (800) cycles after that edge.
- R3: If the first two scans disagree, one further scan is made and compared with the second. An agreement then makes `req_n_o` fall 2*ROUND_CYC (1600) cycles after the scan started.
- R4: A press released before the second scan samples its line never produces a request. The block returns to idle with the standby pattern on the drive lines.
- R5: Key bit index (0-based) = (d-1)*N_SNS + (s-1), where d is the drive line (1..6) and s is the sense input (1..5). A single pressed key sets only its own bit.
- R6: With `seg_lo_i` high, drive lines 1 and 2 are held low at all times, `key_o[9:0]` reads zero, and a press on those lines alone starts nothing.
- R7: Standby drive pattern, with line 6 in bit 5: sleep bits 00 or 11 drive all lines high, 01 drives only line 6 high, and 10 drives lines 5 and 6 high.
- R8: In sleep, a press on a low standby line is ignored. A press on a high line starts a scan and sets `sleep_ack_o` to 1 with the confirmed image. `osc_en_o` is 0 only in sleep while idle.
- R9: `rd_done_i` releases `req_n_o` on the next edge and starts a new round, which raises the request again if the key is still held. `cs_i` high forces `req_n_o` high, and the latched image is held while the request waits.
- R10: During a scan only one drive line is high at a time. Line k (0-based) is high for cycles k*SLOT to (k+1)*SLOT-1 of the scan, with SLOT = SCAN_CYC/N_DRV (62), and no line is high in the leftover cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock (oscillator) |
| rst_n | input | 1 | Active-low asynchronous reset |
| sense_i | input | N_SNS | Sense inputs from the key matrix |
| sleep_i | input | 2 | Sleep bits; 00 is normal mode |
| seg_lo_i | input | 1 | Drive lines 1 and 2 taken for other use |
| cs_i | input | 1 | Serial chip-enable; masks the request |
| rd_done_i | input | 1 | One-cycle strobe: host finished reading |
| drv_o | output | N_DRV | Drive lines, line 1 in bit 0 |
| key_o | output | N_DRV*N_SNS | Confirmed key image |
| sleep_ack_o | output | 1 | Asleep when the confirmed press began |
| req_n_o | output | 1 | Active-low read request |
| osc_en_o | output | 1 | Oscillator enable |

## Verification
The confirmation of a key image and the chip-enable mask can fall in the same cycle. To provoke this, the bench holds `cs_i` high across the edge at which the second scan agrees. `req_n_o` must stay high through that edge and fall as soon as `cs_i` drops, and the image must still be correct. A read-done strobe that comes while the key is still held has to release the request and then restart the full 800-cycle confirmation; the bench measures the cycles until the request falls again. The arithmetic sweep presses each of the thirty keys alone and checks the single bit it expects together with the 800-cycle latency.

// File: rtl/kms_pkg.sv
package kms_pkg;
   typedef enum logic [1:0] {
      KS_IDLE = 2'd0,
      KS_SCAN = 2'd1,
      KS_WAIT = 2'd2
   } kms_state_t;
endpackage

// File: rtl/kms_timer.sv
module kms_timer #(
   parameter int N_DRV     = 6,
   parameter int SCAN_CYC  = 375,
   parameter int ROUND_CYC = 800,
   parameter int LW        = $clog2(N_DRV + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          run_i,
   output logic [LW-1:0] line_o,
   output logic          strobe_o,
   output logic          sample_o,
   output logic          scan_end_o,
   output logic          round_end_o
);
   localparam int SLOT = SCAN_CYC / N_DRV;
   localparam int CW   = $clog2(ROUND_CYC);
   localparam int SW   = $clog2(SLOT + 1);
   localparam logic [CW-1:0] SCAN_C      = CW'(SCAN_CYC);
   localparam logic [CW-1:0] SCAN2_C     = CW'(2 * SCAN_CYC);
   localparam logic [CW-1:0] SCAN_LAST_C = CW'(SCAN_CYC - 1);
   localparam logic [CW-1:0] ROUND_LAST  = CW'(ROUND_CYC - 1);
   localparam logic [SW-1:0] SLOT_LAST   = SW'(SLOT - 1);
   localparam logic [LW-1:0] LINE_END    = LW'(N_DRV);

   logic [CW-1:0] cnt_q, pos;
   logic [SW-1:0] slot_q;
   logic [LW-1:0] line_q;
   logic          first_q, scan_on;

   always_comb begin
      pos         = (first_q && cnt_q >= SCAN_C) ? cnt_q - SCAN_C : cnt_q;
      scan_on     = run_i && ((cnt_q < SCAN_C) || (first_q && cnt_q < SCAN2_C));
      strobe_o    = scan_on && (line_q != LINE_END);
      sample_o    = strobe_o && (slot_q == SLOT_LAST);
      scan_end_o  = scan_on && (pos == SCAN_LAST_C);
      round_end_o = run_i && (cnt_q == ROUND_LAST);
      line_o      = line_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         slot_q  <= '0;
         line_q  <= '0;
         first_q <= 1'b0;
      end else if (start_i) begin
         cnt_q   <= '0;
         slot_q  <= '0;
         line_q  <= '0;
         first_q <= 1'b1;
      end else if (run_i) begin
         cnt_q <= round_end_o ? '0 : cnt_q + 1'b1;
         if (round_end_o) first_q <= 1'b0;
         if (scan_end_o || round_end_o) begin
            slot_q <= '0;
            line_q <= '0;
         end else if (strobe_o) begin
            if (slot_q == SLOT_LAST) begin
               slot_q <= '0;
               line_q <= line_q + 1'b1;
            end else begin
               slot_q <= slot_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/kms_capture.sv
module kms_capture #(
   parameter int N_DRV = 6,
   parameter int N_SNS = 5,
   parameter int LW    = $clog2(N_DRV + 1),
   parameter int N_KEY = N_DRV * N_SNS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             sample_i,
   input  logic             scan_end_i,
   input  logic [LW-1:0]    line_i,
   input  logic [N_SNS-1:0] sense_i,
   output logic [N_KEY-1:0] last_o,
   output logic             agree_o,
   output logic             empty_o
);
   logic [N_KEY-1:0] cur_q, nxt, last_q, prior_q;

   for (genvar i = 0; i < N_DRV; i++) begin : g_row
      assign nxt[i*N_SNS +: N_SNS] = (sample_i && line_i == LW'(i)) ?
                                     sense_i : cur_q[i*N_SNS +: N_SNS];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q   <= '0;
         last_q  <= '0;
         prior_q <= '0;
      end else if (start_i) begin
         cur_q   <= '0;
         last_q  <= '0;
         prior_q <= '0;
      end else if (scan_end_i) begin
         cur_q   <= '0;
         last_q  <= nxt;
         prior_q <= last_q;
      end else begin
         cur_q   <= nxt;
      end
   end

   assign last_o  = last_q;
   assign agree_o = (last_q == prior_q);
   assign empty_o = ~|last_q;
endmodule

// File: rtl/kms_drive.sv
module kms_drive #(
   parameter int N_DRV = 6,
   parameter int LW    = $clog2(N_DRV + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             strobe_i,
   input  logic [LW-1:0]    line_i,
   input  logic [1:0]       sleep_i,
   input  logic             seg_lo_i,
   output logic [N_DRV-1:0] drv_o
);
   for (genvar i = 0; i < N_DRV; i++) begin : g_line
      localparam bit IS_SEG  = (i < 2);
      localparam bit IS_TOP  = (i == N_DRV - 1);
      localparam bit IS_TOP2 = (i >= N_DRV - 2);
      logic idle_hi;
      always_comb begin
         case (sleep_i)
            2'b01:   idle_hi = IS_TOP;
            2'b10:   idle_hi = IS_TOP2;
            default: idle_hi = 1'b1;
         endcase
         if (IS_SEG && seg_lo_i) drv_o[i] = 1'b0;
         else if (run_i)         drv_o[i] = strobe_i && (line_i == LW'(i));
         else                    drv_o[i] = idle_hi;
      end
   end

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> $onehot0(drv_o)); // R10
endmodule

// File: rtl/key_matrix_scanner.sv
module key_matrix_scanner #(
   parameter int N_DRV     = 6,
   parameter int N_SNS     = 5,
   parameter int SCAN_CYC  = 375,
   parameter int ROUND_CYC = 800
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_SNS-1:0]       sense_i,
   input  logic [1:0]             sleep_i,
   input  logic                   seg_lo_i,
   input  logic                   cs_i,
   input  logic                   rd_done_i,
   output logic [N_DRV-1:0]       drv_o,
   output logic [N_DRV*N_SNS-1:0] key_o,
   output logic                   sleep_ack_o,
   output logic                   req_n_o,
   output logic                   osc_en_o
);
   import kms_pkg::*;

   localparam int N_KEY = N_DRV * N_SNS;
   localparam int LW    = $clog2(N_DRV + 1);
   localparam logic [N_KEY-1:0] LO_MASK = {{(N_KEY-2*N_SNS){1'b0}}, {(2*N_SNS){1'b1}}};

   initial begin : g_param_chk
      assert (N_DRV >= 3) else $error("N_DRV must be at least 3");
      assert (N_SNS >= 1) else $error("N_SNS must be at least 1");
      assert (SCAN_CYC >= 2 * N_DRV) else $error("SCAN_CYC too short for N_DRV slots");
      assert (2 * SCAN_CYC < ROUND_CYC) else $error("ROUND_CYC must exceed two scans");
   end

   kms_state_t       st_q;
   logic [N_KEY-1:0] img_q, last_img;
   logic             sak_q, cap_q;
   logic             start, run, strobe, sample, scan_end, round_end, agree, empty;
   logic [LW-1:0]    line;

   assign run   = (st_q == KS_SCAN);
   assign start = ((st_q == KS_IDLE) && (|sense_i)) || ((st_q == KS_WAIT) && rd_done_i);

   kms_timer #(.N_DRV(N_DRV), .SCAN_CYC(SCAN_CYC), .ROUND_CYC(ROUND_CYC), .LW(LW)) u_timer (
      .clk(clk), .rst_n(rst_n), .start_i(start), .run_i(run), .line_o(line),
      .strobe_o(strobe), .sample_o(sample), .scan_end_o(scan_end), .round_end_o(round_end));

   kms_capture #(.N_DRV(N_DRV), .N_SNS(N_SNS), .LW(LW), .N_KEY(N_KEY)) u_capture (
      .clk(clk), .rst_n(rst_n), .start_i(start), .sample_i(sample), .scan_end_i(scan_end),
      .line_i(line), .sense_i(sense_i), .last_o(last_img), .agree_o(agree), .empty_o(empty));

   kms_drive #(.N_DRV(N_DRV), .LW(LW)) u_drive (
      .clk(clk), .rst_n(rst_n), .run_i(run), .strobe_i(strobe), .line_i(line),
      .sleep_i(sleep_i), .seg_lo_i(seg_lo_i), .drv_o(drv_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= KS_IDLE;
         img_q <= '0;
         sak_q <= 1'b0;
         cap_q <= 1'b0;
      end else begin
         case (st_q)
            KS_IDLE: if (|sense_i) begin
               st_q  <= KS_SCAN;
               cap_q <= |sleep_i;
            end
            KS_SCAN: if (round_end) begin
               if (agree && !empty) begin
                  st_q  <= KS_WAIT;
                  img_q <= last_img;
                  sak_q <= cap_q;
               end else if (agree) begin
                  st_q  <= KS_IDLE;
               end
            end
            KS_WAIT: if (rd_done_i) st_q <= KS_SCAN;
            default: st_q <= KS_IDLE;
         endcase
      end
   end

   assign key_o       = img_q & ~(seg_lo_i ? LO_MASK : '0);
   assign sleep_ack_o = sak_q;
   assign req_n_o     = (st_q != KS_WAIT) || cs_i;
   assign osc_en_o    = (sleep_i == 2'b00) || (st_q != KS_IDLE);

   AST_RESET_REQ: assert property (@(posedge clk)
      !rst_n |-> req_n_o); // R1
   AST_CONFIRM_AT_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q == KS_WAIT) |-> $past(round_end)); // R2
   AST_IMG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == KS_WAIT && !rd_done_i) |=> $stable(img_q)); // R9
   AST_SAK_ON_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
      !(run && round_end) |=> $stable(sak_q)); // R8
endmodule

// File: tb/tb_key_matrix_scanner.sv
`timescale 1ns/1ps
module tb_key_matrix_scanner;
   localparam int ND = 6, NS = 5, NK = 30, RND = 800;

   logic          clk = 1'b0, rst_n = 1'b0, seg = 1'b0, cs = 1'b0, rd = 1'b0;
   logic [1:0]    slp = 2'b00;
   logic [NS-1:0] sense;
   logic [ND-1:0] drv;
   logic [NK-1:0] keys = '0, key;
   logic          sak, req_n, osc_en;
   int            checks = 0, fails = 0, n = 0;

   always #2.5 clk = ~clk;

   key_matrix_scanner dut (
      .clk(clk), .rst_n(rst_n), .sense_i(sense), .sleep_i(slp), .seg_lo_i(seg),
      .cs_i(cs), .rd_done_i(rd), .drv_o(drv), .key_o(key), .sleep_ack_o(sak),
      .req_n_o(req_n), .osc_en_o(osc_en));

   always_comb begin
      for (int s = 0; s < NS; s++) begin
         sense[s] = 1'b0;
         for (int d = 0; d < ND; d++) sense[s] = sense[s] | (drv[d] & keys[d*NS+s]);
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic settle(input int c);
      repeat (c) @(negedge clk);
   endtask

   task automatic wait_req(input int limit, output int cnt);
      cnt = 0;
      while (req_n && cnt < limit) begin
         @(negedge clk);
         cnt++;
      end
   endtask

   task automatic read_pulse();
      @(negedge clk) rd = 1'b1;
      @(negedge clk) rd = 1'b0;
   endtask

   task automatic release_all();
      keys = '0;
      read_pulse();
      settle(RND + 50);
   endtask

   function automatic logic [ND-1:0] idle_pat(input logic [1:0] s, input logic lo);
      logic [ND-1:0] p;
      case (s)
         2'b01:   p = 6'b100000;
         2'b10:   p = 6'b110000;
         default: p = 6'b111111;
      endcase
      return lo ? (p & 6'b111100) : p;
   endfunction

   initial begin : watchdog
      repeat (195000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin : stim
      settle(5);
      // R1 reset state, press ignored during reset
      chk("R1 key", 32'(key), 0);
      chk("R1 req", 32'(req_n), 1);
      chk("R1 sak", 32'(sak), 0);
      keys = 30'(1) << 7;
      settle(1000);
      chk("R1 req held in reset", 32'(req_n), 1);
      chk("R1 key held in reset", 32'(key), 0);
      keys = '0;
      settle(3);
      rst_n = 1'b1;
      settle(3);

      // R7 standby patterns, R8 oscillator enable in idle
      for (int s = 0; s < 4; s++) begin
         slp = 2'(s);
         settle(2);
         chk("R7 idle pattern", 32'(drv), 32'(idle_pat(2'(s), 1'b0)));
         chk("R8 osc_en idle", 32'(osc_en), 32'(s == 0));
      end
      slp = 2'b00;
      settle(2);

      // R2 latency, R10 strobe slots
      keys = 30'(1);
      n = 0;
      while (req_n && n < 2000) begin
         @(negedge clk);
         n++;
         if (n == 11)  chk("R10 line1 slot", 32'(drv), 32'h01);
         if (n == 71)  chk("R10 line2 slot", 32'(drv), 32'h02);
         if (n == 320) chk("R10 line6 slot", 32'(drv), 32'h20);
         if (n == 374) chk("R10 tail gap", 32'(drv), 32'h00);
      end
      chk("R2 latency", 32'(n), RND + 1);
      chk("R2 key", 32'(key), 32'h1);
      chk("R2 sak", 32'(sak), 0);
      // R9 read while held: release, then re-request after a full round
      read_pulse();
      chk("R9 released", 32'(req_n), 1);
      wait_req(2000, n);
      chk("R9 re-request latency", 32'(n), RND);
      release_all();
      chk("R4 idle req", 32'(req_n), 1);
      chk("R4 idle drive", 32'(drv), 32'h3F);

      // R5 sweep over every key
      for (int k = 0; k < NK; k++) begin
         keys = 30'(1) << k;
         wait_req(2000, n);
         chk("R2 sweep latency", 32'(n), RND + 1);
         chk("R5 key bit", 32'(key), 32'(30'(1) << k));
         release_all();
      end

      // R3 disagreeing scans
      keys = 30'(1) << 25;
      settle(400);
      keys = keys | (30'(1) << 26);
      wait_req(2000, n);
      chk("R3 retry latency", 32'(n + 400), 2 * RND + 1);
      chk("R3 key", 32'(key), 32'(30'(3) << 25));
      release_all();

      // R4 short press
      keys = 30'(1) << 27;
      settle(500);
      keys = '0;
      wait_req(2000, n);
      chk("R4 no request", 32'(req_n), 1);
      chk("R4 back to standby", 32'(drv), 32'h3F);

      // R6 lower lines taken
      seg = 1'b1;
      settle(2);
      chk("R6 standby", 32'(drv), 32'(idle_pat(2'b00, 1'b1)));
      keys = 30'(1) << 3;
      settle(1000);
      chk("R6 no trigger", 32'(req_n), 1);
      keys = (30'(1) << 3) | (30'(1) << 12);
      wait_req(2000, n);
      chk("R6 masked image", 32'(key), 32'(30'(1) << 12));
      release_all();
      seg = 1'b0;

      // R8 sleep wake
      slp = 2'b01;
      settle(2);
      keys = 30'(1) << 2;
      settle(1000);
      chk("R8 low line ignored", 32'(req_n), 1);
      chk("R8 osc off", 32'(osc_en), 0);
      keys = 30'(1) << 27;
      settle(5);
      chk("R8 osc woken", 32'(osc_en), 1);
      wait_req(2000, n);
      chk("R8 sleep ack", 32'(sak), 1);
      chk("R8 key", 32'(key), 32'(30'(1) << 27));
      release_all();
      chk("R8 osc off again", 32'(osc_en), 0);
      slp = 2'b00;
      settle(2);

      // R9 chip-enable high across the confirmation edge
      cs = 1'b1;
      keys = 30'(1) << 14;
      wait_req(900, n);
      chk("R9 masked by cs", 32'(req_n), 1);
      @(negedge clk) cs = 1'b0;
      #1;
      chk("R9 request after cs", 32'(req_n), 0);
      chk("R9 key", 32'(key), 32'(30'(1) << 14));
      chk("R8 normal ack", 32'(sak), 0);
      release_all();

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule